// File: doc/BRIEF.md
# Radio Self-Calibration Sequencer

This block runs on the host side of a radio link. After power-up it configures the transceiver and then takes it through its calibration. A single start pulse starts a fixed series of seven register writes, sent through a serial control-port master. The master is modelled as a request/acknowledge handshake that carries a 5-bit register address and a 16-bit data word.

The first write programs the synthesizer control register. It carries the reference-divider code and the channel code, which are inputs latched when the start is accepted. The next five writes go to the mode control register. They hold the transceiver in manual power control, with the crystal oscillator and the demodulator-clock multiplier kept on, and set one calibration group at a time. The last write clears that register, so chip control returns to the transceiver's own state machine.

After each write is acknowledged, the block waits a settle time before it issues the next write. The time is counted in microseconds by a prescaler that runs from the system clock. A busy flag covers the whole run and a one-cycle done pulse ends it. Inputs that are not valid raise an error flag, and no write is issued.

Top module: `cal_sequencer`

## Requirements
- R1: After a start is accepted, busy is high from the next cycle until the cycle in which the last write is acknowledged. Done is a one-cycle pulse in the cycle after that acknowledge, with busy already low.
- R2: The writes go out in this order, as (address, data): (7, step-1 word), (5, 16'h80C0), (5, 16'h84C0), (5, 16'h8AC0), (5, 16'h80E0), (5, 16'h80D0), (5, 16'h0000).
- R3: The step-1 word has the following fields:
  - bit 8 (transmit enable) is set;
  - bits 11:9 hold the reference-divider code;
  - bits 6:0 hold the channel code;
  - all other bits are zero.
- R4: The next request rises exactly W*TICKS_PER_US clock cycles after the clock edge that takes the acknowledge of a write. W is the wait for that write in microseconds: 0, 2500, 1024, 285, 1608 and 64 for writes 1 to 6. With a wait of 0, the next request is present in the very next cycle.
- R5: A request holds its address and data steady, and stays high, until it is acknowledged.
- R6: A start that arrives while busy is ignored. The run continues unchanged and the error flag stays low.
- R7: A start is rejected if the channel code is outside 3..81 or the divider code is below 3 (the valid codes are 011 for 12 MHz, 100 for 10 MHz, 101 for 11 MHz, 110 for 13 MHz and 111 for 20 MHz). A rejected start sets the error flag from the next cycle, and no request or busy follows. The flag clears when a start is accepted.
- R8: The channel and divider inputs are captured when a start is accepted. Later changes to them do not alter the words written.
- R9: After reset, request, busy, done and error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| ref_code_i | input | 3 | Reference-divider code |
| chan_i | input | 7 | Channel code (LO frequency minus 2400 MHz) |
| wr_req_o | output | 1 | Write request to serial master |
| wr_addr_o | output | 5 | Register address of the request |
| wr_data_o | output | 16 | Register data of the request |
| wr_ack_i | input | 1 | Write acknowledge from serial master (one cycle) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at end of sequence |
| err_o | output | 1 | Last start rejected for invalid inputs |

## Verification
The checker assertions hold on every cycle for the following behaviours:
- a pending request stays stable until it is acknowledged;
- requests and errors only appear in the right busy state;
- done follows an acknowledge;
- the synchronizer-write word carries transmit enable and a legal channel;
- a zero-wait write is followed at once by the next request.

Other behaviours can only be shown by the bench scenarios:
- the exact order of the register images;
- the exact cycle counts of each settle window;
- that inputs are latched at start;
- the rejection of boundary channel and divider codes.

The bench covers these by using a serial-master model with random acknowledge delays, and by comparing against tables it computes itself.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  localparam int NUM_STEPS = 7;
  localparam int STEP_W    = 3;
  localparam int US_W      = 12;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int CH_W      = 7;
  localparam int REF_W     = 3;

  localparam logic [ADDR_W-1:0] SYNTH_ADDR = 5'd7;
  localparam logic [ADDR_W-1:0] MODE_ADDR  = 5'd5;

  // manual power control, crystal on, demod multiplier on
  localparam logic [DATA_W-1:0] HOLD_BITS  = 16'h80C0;

  localparam logic [CH_W-1:0]  CH_MIN  = 7'd3;
  localparam logic [CH_W-1:0]  CH_MAX  = 7'd81;
  localparam logic [REF_W-1:0] REF_MIN = 3'd3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_state_t;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [STEP_W-1:0] idx);
    return (idx == '0) ? SYNTH_ADDR : MODE_ADDR;
  endfunction

  function automatic logic [DATA_W-1:0] step_data(input logic [STEP_W-1:0] idx,
                                                  input logic [REF_W-1:0]  refc,
                                                  input logic [CH_W-1:0]   ch);
    logic [DATA_W-1:0] d;
    case (idx)
      3'd0:    d = {4'b0000, refc, 1'b1, 1'b0, ch};
      3'd1:    d = HOLD_BITS;
      3'd2:    d = HOLD_BITS | 16'h0400;  // IF loop gain
      3'd3:    d = HOLD_BITS | 16'h0A00;  // shaping filter + RX gain
      3'd4:    d = HOLD_BITS | 16'h0020;  // IF filters
      3'd5:    d = HOLD_BITS | 16'h0010;  // RX offset
      default: d = '0;                    // hand back control
    endcase
    return d;
  endfunction

  function automatic logic [US_W-1:0] step_wait_us(input logic [STEP_W-1:0] idx);
    logic [US_W-1:0] w;
    case (idx)
      3'd1:    w = 12'd2500;
      3'd2:    w = 12'd1024;
      3'd3:    w = 12'd285;
      3'd4:    w = 12'd1608;
      3'd5:    w = 12'd64;
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cal_us_prescaler.sv
module cal_us_prescaler #(
  parameter int TICKS_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_US - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cal_settle_timer.sv
module cal_settle_timer
  import cal_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  input  logic            tick,
  output logic            expire
);
  logic [US_W-1:0] us_q, us_d;
  logic            us_en;

  assign expire = tick && (us_q == US_W'(1));
  assign us_en  = load || (tick && (us_q != '0));

  always_comb begin
    if (load) us_d = load_us;
    else      us_d = us_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     us_q <= '0;
    else if (us_en) us_q <= us_d;
  end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int TICKS_PER_US = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [REF_W-1:0]  ref_code_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic              rst_n_s;
  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [REF_W-1:0]  ref_q;
  logic [CH_W-1:0]   ch_q;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              capture, tmr_load, us_tick, tmr_expire, inputs_ok;
  logic [US_W-1:0]   cur_wait;

  cal_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  cal_us_prescaler #(.TICKS_PER_US(TICKS_PER_US)) u_presc (
    .clk(clk), .rst_n(rst_n_s), .restart(tmr_load), .tick(us_tick)
  );

  cal_settle_timer u_tmr (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_load), .load_us(cur_wait),
    .tick(us_tick), .expire(tmr_expire)
  );

  assign inputs_ok = (ref_code_i >= REF_MIN) && (chan_i >= CH_MIN) && (chan_i <= CH_MAX);
  assign cur_wait  = step_wait_us(step_q);

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    done_d   = 1'b0;
    err_d    = err_q;
    capture  = 1'b0;
    tmr_load = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          if (inputs_ok) begin
            state_d = S_REQ;
            step_d  = '0;
            capture = 1'b1;
            err_d   = 1'b0;
          end else begin
            err_d   = 1'b1;
          end
        end
      end
      S_REQ: begin
        if (wr_ack_i) begin
          if (cur_wait != '0) begin
            tmr_load = 1'b1;
            state_d  = S_WAIT;
          end else if (step_q == LAST_STEP) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      S_WAIT: begin
        if (tmr_expire) begin
          state_d = S_REQ;
          step_d  = step_q + 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ref_q <= '0;
      ch_q  <= '0;
    end else if (capture) begin
      ref_q <= ref_code_i;
      ch_q  <= chan_i;
    end
  end

  assign wr_req_o  = (state_q == S_REQ);
  assign wr_addr_o = step_addr(step_q);
  assign wr_data_o = step_data(step_q, ref_q, ch_q);
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        wr_req_o,
  input logic [4:0]  wr_addr_o,
  input logic [15:0] wr_data_o,
  input logic        wr_ack_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_done_after_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(wr_ack_i)));

  assert_req_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> busy_o);

  assert_synth_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && wr_addr_o == 5'd7) |->
      (wr_data_o[8] && wr_data_o[6:0] >= 7'd3 && wr_data_o[6:0] <= 7'd81));

  assert_zero_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && wr_ack_i && wr_addr_o == 5'd7) |=> wr_req_o);

  assert_busy_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !wr_ack_i) |=> busy_o);

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o);

  assert_no_err_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !err_o);
endmodule

bind cal_sequencer cal_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_req_o(wr_req_o),
  .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/cal_sequencer_tb.sv
module cal_sequencer_tb;
  localparam int T = 2;
  localparam int NW = 7;

  logic clk = 1'b0;
  logic rst_n, start_i, wr_ack_i;
  logic [2:0] ref_code_i;
  logic [6:0] chan_i;
  logic wr_req_o, busy_o, done_o, err_o;
  logic [4:0] wr_addr_o;
  logic [15:0] wr_data_o;

  int checks = 0, fails = 0, cyc = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  cal_sequencer #(.TICKS_PER_US(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_code_i(ref_code_i),
    .chan_i(chan_i), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  always @(negedge clk) cyc++;

  function automatic logic [4:0] e_addr(int i);
    return (i == 0) ? 5'd7 : 5'd5;
  endfunction

  function automatic logic [15:0] e_data(int i, logic [2:0] rc, logic [6:0] ch);
    case (i)
      0: return (16'(rc) << 9) | 16'h0100 | 16'(ch);
      1: return 16'h80C0;
      2: return 16'h84C0;
      3: return 16'h8AC0;
      4: return 16'h80E0;
      5: return 16'h80D0;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int e_wait(int i);
    case (i)
      1: return 2500;
      2: return 1024;
      3: return 285;
      4: return 1608;
      5: return 64;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_bench();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic err_case(input logic [6:0] ch, input logic [2:0] rc);
    @(negedge clk);
    start_i = 1; chan_i = ch; ref_code_i = rc;
    @(negedge clk);
    start_i = 0;
    chk(err_o == 1'b1, "R7 err set", err_o, 1);
    chk(busy_o == 1'b0 && wr_req_o == 1'b0, "R7 no run", {busy_o, wr_req_o}, 0);
    repeat (3) @(negedge clk);
    chk(wr_req_o == 1'b0 && err_o == 1'b1, "R7 stays idle", {wr_req_o, err_o}, 1);
  endtask

  task automatic run_seq(input logic [6:0] ch, input logic [2:0] rc, input bit poke);
    int widx = 0, dly = 0, t_ack = 0, exp_gap = 1;
    bit pending = 1, fin = 0, poked = 0;
    @(negedge clk);
    start_i = 1; chan_i = ch; ref_code_i = rc;
    @(negedge clk);
    start_i = 0;
    t_ack = cyc - 1;
    chk(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
    chk(err_o == 1'b0, "R7 err cleared by accepted start", err_o, 0);
    // R8: inputs change after capture
    chan_i = ~ch; ref_code_i = 3'd1;
    while (!fin) begin
      if (poke && start_i) start_i = 0;
      if (wr_ack_i) begin
        wr_ack_i = 0;
        if (widx == NW) begin
          chk(done_o == 1'b1 && busy_o == 1'b0, "R1 done and busy low", {done_o, busy_o}, 2);
          chk(wr_req_o == 1'b0 && err_o == 1'b0, "R6 no restart or error", {wr_req_o, err_o}, 0);
          @(negedge clk);
          chk(done_o == 1'b0, "R1 done one cycle", done_o, 0);
          fin = 1;
        end
      end
      if (!fin) begin
        if (pending && wr_req_o) begin
          chk(cyc - t_ack == exp_gap, "R4 settle gap", cyc - t_ack, exp_gap);
          pending = 0;
          dly = $urandom_range(0, 3);
        end else if (!pending && wr_req_o && !wr_ack_i) begin
          if (dly == 0) begin
            chk(wr_addr_o == e_addr(widx) && wr_data_o == e_data(widx, rc, ch),
                (widx == 0) ? "R3 R8 synth word" : "R2 write image",
                {wr_addr_o, wr_data_o}, {e_addr(widx), e_data(widx, rc, ch)});
            chk(busy_o == 1'b1, "R1 busy during run", busy_o, 1);
            wr_ack_i = 1;
            t_ack = cyc;
            exp_gap = e_wait(widx) * T + 1;
            widx++;
            pending = (widx < NW);
          end else dly--;
        end
        if (poke && !poked && widx == 3 && pending) begin
          start_i = 1; chan_i = 7'd10; ref_code_i = 3'd0; // R6 start while busy
          poked = 1;
        end
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_bench();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; start_i = 0; wr_ack_i = 0; chan_i = 7'd40; ref_code_i = 3'd3;
    repeat (3) @(negedge clk);
    chk({wr_req_o, busy_o, done_o, err_o} == 4'b0, "R9 reset state",
        {wr_req_o, busy_o, done_o, err_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk({wr_req_o, busy_o, done_o, err_o} == 4'b0, "R9 after release",
        {wr_req_o, busy_o, done_o, err_o}, 0);

    err_case(7'd2, 3'd3);
    err_case(7'd82, 3'd6);
    err_case(7'd0, 3'd7);
    err_case(7'd40, 3'd2);

    run_seq(7'd3, 3'b011, 1'b0);
    run_seq(7'd81, 3'b111, 1'b1);
    for (int k = 0; k < 2; k++) begin
      logic [6:0] ch;
      logic [2:0] rc;
      ch = 7'($urandom_range(3, 81));
      rc = 3'($urandom_range(3, 7));
      run_seq(ch, rc, 1'b0);
    end
    err_case(7'd127, 3'd4);
    finish_bench();
  end
endmodule